// File: doc/BRIEF.md
# Grouped-Priority Preemptive Interrupt Arbiter

This block collects a set of interrupt request lines. For each line it keeps an enable bit, a pending bit, an active bit and a 4-bit urgency value. Every cycle it picks the single request that should go to the processor next. It offers that request on a registered take interface and, when the processor accepts it, moves the line from pending to active. When a handler finishes, the processor pulses an exit input with the line number, and that line is no longer active.

A programmable group setting splits each 4-bit urgency value into a preemption field (the upper bits) and a sub-priority field (the lower bits). While nothing is active, the most urgent enabled pending request is offered. While handlers are active, a request is offered only if its preemption field is strictly more urgent than the most urgent preemption field among the active lines. The sub-priority field only orders requests that are waiting. The group setting is guarded by a 16-bit key, so a stray write cannot change it.

Software reaches the enable, pending, active, urgency and group state through a word-addressed register port. Read data is registered. Vector fetch, context saving and the processor itself are outside the block.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Word 0 sets enable bits and word 1 clears them. A 1 in a data bit acts on that line and a 0 leaves it unchanged. Reading either word returns the enable bits in bits [N-1:0].
- R2: Word 2 sets pending bits and word 3 clears them, both write-one-only, and either word reads back the pending bits. A high `irq_req` bit sets that line's pending bit. Within one cycle, a set (from the register or from `irq_req`) wins over a clear or an accept.
- R3: Word 4 returns the active bits and ignores writes. An accept sets the line's active bit. An `exit_valid` pulse clears the active bit of `exit_line`. An accept and an exit of different lines in the same cycle both take effect.
- R4: Word 16+k holds the urgency of lines 4k..4k+3, with line 4k+j in byte j. The value is stored in bits [7:4] of the byte, and bits [3:0] always read as 0.
- R5: Word 5 holds a 3-bit group code in bits [10:8]. A write changes the code only when data bits [31:16] equal 0x05FA. The rest of the word reads as 0. The code stores the inverted group: code = 7-g, so g preemption bits are taken from the top of the urgency field, and codes 0..2 act as g=4.
- R6: Among the enabled pending lines, the offered line has the lowest 4-bit urgency value, which means the lowest preemption field first and then the lowest sub-priority. Ties go to the lowest line number. A disabled line is never offered.
- R7: While any line is active, a request is offered only if its preemption field is numerically lower than the lowest preemption field among the active lines. An equal preemption field waits whatever its sub-priority. Once the blocking handler exits, the waiting request is offered.
- R8: `take_valid` and `take_line` are registered. A pending bit that appears at one clock edge is offered after the next edge. `take_ack` while `take_valid` is high, with the offered line still enabled and pending, is an accept. After an accept `take_valid` is low for one cycle. An ack for a line that is no longer pending is ignored.
- R9: After reset, enable, pending, active and urgency are all zero, the group code is 7, and `take_valid` is low. `reg_rdata` shows the word addressed at the previous clock edge, and an unmapped word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_LINES | Request lines; a high bit sets that line pending |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the word addressed at the last edge |
| take_ack | input | 1 | Processor accepts the offered line |
| exit_valid | input | 1 | Handler completion pulse |
| exit_line | input | $clog2(N_LINES) | Line whose handler completed |
| take_valid | output | 1 | A line is offered to the processor |
| take_line | output | $clog2(N_LINES) | Number of the offered line |

## Verification
Two pairs of events can fall in the same clock edge. An accept can coincide with an exit of another line, and an accept can coincide with a fresh request on the line being accepted. The bench drives `take_ack` together with `exit_valid`, or together with an `irq_req` bit, in one cycle. It then reads the active and pending words and expects both updates to be present. A third collision puts a pending-clear write in the cycle just before an ack, and the bench expects the stale ack to leave the active word empty. Around these, the bench sweeps every group code against every pair of urgency values for an active and a waiting line, and computes the preempt-or-wait outcome arithmetically.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int DATA_W         = 32;
  localparam int LINES_PER_WORD = 4;
  localparam int GRP_LSB        = 8;
  localparam logic [15:0] GRP_KEY = 16'h05FA;

  // register word map
  localparam int A_EN_SET    = 0;
  localparam int A_EN_CLR    = 1;
  localparam int A_PND_SET   = 2;
  localparam int A_PND_CLR   = 3;
  localparam int A_ACTIVE    = 4;
  localparam int A_GROUP     = 5;
  localparam int A_PRIO_BASE = 16;

  // number of preemption bits taken from the top of the urgency field
  function automatic int unsigned preempt_bits(input logic [2:0] code,
                                               input int unsigned prio_w);
    int unsigned g;
    g = 32'd7 - 32'(code);
    return (g > prio_w) ? prio_w : g;
  endfunction

endpackage

// File: rtl/irq_min_tree.sv
// Balanced minimum tree: returns the smallest key among valid leaves.
// The left subtree wins ties, so lower leaf numbers are preferred.
module irq_min_tree #(
  parameter int N_LEAF = 32,
  parameter int KEY_W  = 4
) (
  input  logic [N_LEAF-1:0]       leaf_vld,
  input  logic [N_LEAF*KEY_W-1:0] leaf_key,
  output logic                    best_vld,
  output logic [KEY_W-1:0]        best_key
);
  localparam int NODES = 2 * N_LEAF - 1;

  logic             nv [NODES];
  logic [KEY_W-1:0] nk [NODES];

  for (genvar k = 0; k < N_LEAF; k++) begin : g_leaf
    assign nv[N_LEAF-1+k] = leaf_vld[k];
    assign nk[N_LEAF-1+k] = leaf_key[k*KEY_W +: KEY_W];
  end

  for (genvar i = 0; i < N_LEAF - 1; i++) begin : g_node
    logic take_l;
    assign take_l = nv[2*i+1] && (!nv[2*i+2] || (nk[2*i+1] <= nk[2*i+2]));
    assign nv[i]  = nv[2*i+1] || nv[2*i+2];
    assign nk[i]  = take_l ? nk[2*i+1] : nk[2*i+2];
  end

  assign best_vld = nv[0];
  assign best_key = nk[0];
endmodule

// File: rtl/irq_line_state.sv
// Per-line enable, pending, active and urgency state.
module irq_line_state #(
  parameter int N_LINES = 32,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_LINES-1:0]        en_set,
  input  logic [N_LINES-1:0]        en_clr,
  input  logic [N_LINES-1:0]        pnd_set,
  input  logic [N_LINES-1:0]        pnd_clr,
  input  logic [N_LINES-1:0]        irq_req,
  input  logic                      acc_vld,
  input  logic [IDX_W-1:0]          acc_line,
  input  logic                      ext_vld,
  input  logic [IDX_W-1:0]          ext_line,
  input  logic [N_LINES-1:0]        prio_we,
  input  logic [N_LINES*PRIO_W-1:0] prio_wval,
  output logic [N_LINES-1:0]        en_q,
  output logic [N_LINES-1:0]        pend_q,
  output logic [N_LINES-1:0]        act_q,
  output logic [N_LINES*PRIO_W-1:0] prio_q
);
  logic [N_LINES-1:0] acc_mask, ext_mask;

  assign acc_mask = acc_vld ? (N_LINES'(1) << acc_line) : '0;
  assign ext_mask = ext_vld ? (N_LINES'(1) << ext_line) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      en_q   <= (en_q | en_set) & ~en_clr;
      pend_q <= (pend_q & ~pnd_clr & ~acc_mask) | pnd_set | irq_req;
      act_q  <= (act_q & ~ext_mask) | acc_mask;
    end
  end

  for (genvar k = 0; k < N_LINES; k++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst)             prio_q[k*PRIO_W +: PRIO_W] <= '0;
      else if (prio_we[k]) prio_q[k*PRIO_W +: PRIO_W] <= prio_wval[k*PRIO_W +: PRIO_W];
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 5,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_req,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               take_ack,
  input  logic               exit_valid,
  input  logic [IDX_W-1:0]   exit_line,
  output logic               take_valid,
  output logic [IDX_W-1:0]   take_line
);
  localparam int PRIO_WORDS = (N_LINES + LINES_PER_WORD - 1) / LINES_PER_WORD;
  localparam int WKEY_W     = PRIO_W + IDX_W;

  logic [N_LINES-1:0]        en_q, pend_q, act_q;
  logic [N_LINES*PRIO_W-1:0] prio_q;
  logic [2:0]                grp_code_q;

  // ---------------- register decode ----------------
  logic [N_LINES-1:0]        en_set, en_clr, pnd_set, pnd_clr, prio_we;
  logic [N_LINES*PRIO_W-1:0] prio_wval;
  logic                      in_prio;
  logic [ADDR_W-1:0]         prio_word;

  assign en_set  = (reg_we && reg_addr == ADDR_W'(A_EN_SET))  ? reg_wdata[N_LINES-1:0] : '0;
  assign en_clr  = (reg_we && reg_addr == ADDR_W'(A_EN_CLR))  ? reg_wdata[N_LINES-1:0] : '0;
  assign pnd_set = (reg_we && reg_addr == ADDR_W'(A_PND_SET)) ? reg_wdata[N_LINES-1:0] : '0;
  assign pnd_clr = (reg_we && reg_addr == ADDR_W'(A_PND_CLR)) ? reg_wdata[N_LINES-1:0] : '0;

  assign prio_word = reg_addr - ADDR_W'(A_PRIO_BASE);
  assign in_prio   = (reg_addr >= ADDR_W'(A_PRIO_BASE)) &&
                     (reg_addr <  ADDR_W'(A_PRIO_BASE + PRIO_WORDS));

  for (genvar k = 0; k < N_LINES; k++) begin : g_pdec
    assign prio_we[k] = reg_we && in_prio &&
                        (prio_word == ADDR_W'(k / LINES_PER_WORD));
    assign prio_wval[k*PRIO_W +: PRIO_W] =
      reg_wdata[(k % LINES_PER_WORD)*8 + 8 - PRIO_W +: PRIO_W];
  end

  // ---------------- state ----------------
  logic accept;

  irq_line_state #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .pnd_set   (pnd_set),
    .pnd_clr   (pnd_clr),
    .irq_req   (irq_req),
    .acc_vld   (accept),
    .acc_line  (take_line),
    .ext_vld   (exit_valid),
    .ext_line  (exit_line),
    .prio_we   (prio_we),
    .prio_wval (prio_wval),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .act_q     (act_q),
    .prio_q    (prio_q)
  );

  always_ff @(posedge clk) begin
    if (rst)
      grp_code_q <= 3'b111;
    else if (reg_we && reg_addr == ADDR_W'(A_GROUP) && reg_wdata[31:16] == GRP_KEY)
      grp_code_q <= reg_wdata[GRP_LSB +: 3];
  end

  // ---------------- arbitration ----------------
  logic [PRIO_W-1:0]          pre_mask;
  logic [N_LINES*WKEY_W-1:0]  wait_key;
  logic [N_LINES*PRIO_W-1:0]  run_key;
  logic                       win_vld, any_act;
  logic [WKEY_W-1:0]          win_key;
  logic [PRIO_W-1:0]          run_lvl, win_lvl;
  logic                       may_take;

  always_comb pre_mask = ~({PRIO_W{1'b1}} >> preempt_bits(grp_code_q, PRIO_W));

  for (genvar k = 0; k < N_LINES; k++) begin : g_key
    assign wait_key[k*WKEY_W +: WKEY_W] = {prio_q[k*PRIO_W +: PRIO_W], IDX_W'(k)};
    assign run_key[k*PRIO_W +: PRIO_W]  = prio_q[k*PRIO_W +: PRIO_W] & pre_mask;
  end

  irq_min_tree #(.N_LEAF(N_LINES), .KEY_W(WKEY_W)) u_wait_tree (
    .leaf_vld (en_q & pend_q),
    .leaf_key (wait_key),
    .best_vld (win_vld),
    .best_key (win_key)
  );

  irq_min_tree #(.N_LEAF(N_LINES), .KEY_W(PRIO_W)) u_run_tree (
    .leaf_vld (act_q),
    .leaf_key (run_key),
    .best_vld (any_act),
    .best_key (run_lvl)
  );

  assign win_lvl  = win_key[WKEY_W-1 -: PRIO_W] & pre_mask;
  assign may_take = win_vld && (!any_act || (win_lvl < run_lvl));
  assign accept   = take_valid && take_ack && en_q[take_line] && pend_q[take_line];

  always_ff @(posedge clk) begin
    if (rst) begin
      take_valid <= 1'b0;
      take_line  <= '0;
    end else begin
      take_valid <= may_take && !accept;
      take_line  <= win_key[IDX_W-1:0];
    end
  end

  // ---------------- read port ----------------
  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (in_prio) begin
      for (int j = 0; j < LINES_PER_WORD; j++) begin
        if (int'(prio_word) * LINES_PER_WORD + j < N_LINES)
          rd_next[j*8 + 8 - PRIO_W +: PRIO_W] =
            prio_q[(int'(prio_word) * LINES_PER_WORD + j) * PRIO_W +: PRIO_W];
      end
    end else if (reg_addr == ADDR_W'(A_EN_SET) || reg_addr == ADDR_W'(A_EN_CLR)) begin
      rd_next[N_LINES-1:0] = en_q;
    end else if (reg_addr == ADDR_W'(A_PND_SET) || reg_addr == ADDR_W'(A_PND_CLR)) begin
      rd_next[N_LINES-1:0] = pend_q;
    end else if (reg_addr == ADDR_W'(A_ACTIVE)) begin
      rd_next[N_LINES-1:0] = act_q;
    end else if (reg_addr == ADDR_W'(A_GROUP)) begin
      rd_next[GRP_LSB +: 3] = grp_code_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 5,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [15:0]        wr_key,
  input logic [2:0]         wr_code,
  input logic               take_valid,
  input logic [IDX_W-1:0]   take_line,
  input logic               exit_valid,
  input logic [IDX_W-1:0]   exit_line,
  input logic               accept,
  input logic [N_LINES-1:0] en_q,
  input logic [N_LINES-1:0] pend_q,
  input logic [N_LINES-1:0] act_q,
  input logic [2:0]         grp_code_q
);
  logic [N_LINES-1:0] ready_prev;
  logic               grp_wr;

  assign grp_wr = reg_we && (reg_addr == ADDR_W'(irq_arb_pkg::A_GROUP));

  always_ff @(posedge clk) begin
    if (rst) ready_prev <= '0;
    else     ready_prev <= en_q & pend_q;
  end

  // R8: one bubble cycle follows every accept
  p_bubble_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> !take_valid);

  // R3: accepted line becomes active
  p_accept_marks_active_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> act_q[$past(take_line)]);

  // R3: exit clears the line unless the same line is accepted in that cycle
  p_exit_clears_active_r3: assert property (@(posedge clk) disable iff (rst)
    (exit_valid && !(accept && take_line == exit_line)) |=> !act_q[$past(exit_line)]);

  // R3: active bits only rise through an accept, one at a time
  p_active_rise_needs_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (|(act_q & ~$past(act_q))) |-> ($past(accept) && $onehot0(act_q & ~$past(act_q))));

  // R6: an offered line was enabled and pending in the cycle it was chosen
  p_offer_was_ready_r6: assert property (@(posedge clk) disable iff (rst)
    take_valid |-> ready_prev[take_line]);

  // R5: a write without the key leaves the group code alone
  p_group_needs_key_r5: assert property (@(posedge clk) disable iff (rst)
    (grp_wr && wr_key != 16'h05FA) |=> $stable(grp_code_q));

  // R5: a keyed write loads the code
  p_group_keyed_load_r5: assert property (@(posedge clk) disable iff (rst)
    (grp_wr && wr_key == 16'h05FA) |=> (grp_code_q == $past(wr_code)));
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .wr_key     (reg_wdata[31:16]),
  .wr_code    (reg_wdata[10:8]),
  .take_valid (take_valid),
  .take_line  (take_line),
  .exit_valid (exit_valid),
  .exit_line  (exit_line),
  .accept     (accept),
  .en_q       (en_q),
  .pend_q     (pend_q),
  .act_q      (act_q),
  .grp_code_q (grp_code_q)
);

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb;
  localparam int N  = 8;
  localparam int AW = 5;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_req = '0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          take_ack = 1'b0;
  logic          exit_valid = 1'b0;
  logic [IW-1:0] exit_line = '0;
  logic          take_valid;
  logic [IW-1:0] take_line;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_prio_arbiter #(.N_LINES(N), .PRIO_W(4), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .take_ack(take_ack),
    .exit_valid(exit_valid), .exit_line(exit_line),
    .take_valid(take_valid), .take_line(take_line));

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = AW'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse_irq(logic [N-1:0] m);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic do_ack();
    take_ack = 1'b1;
    @(negedge clk);
    take_ack = 1'b0;
  endtask

  task automatic do_exit(int l);
    exit_valid = 1'b1; exit_line = IW'(l);
    @(negedge clk);
    exit_valid = 1'b0;
  endtask

  function automatic int grp_of(int code);
    int g;
    g = 7 - code;
    return (g > 4) ? 4 : g;
  endfunction

  function automatic int mask_of(int g);
    return (15 << (4 - g)) & 15;
  endfunction

  // line 2 is taken first (urgency pa), then line 5 (urgency pb) requests
  task automatic pair_case(int code, int pa, int pb);
    int m;
    bit pre;
    m = mask_of(grp_of(code));
    wr(5, 32'h05FA0000 | (code << 8));
    wr(16, pa << 20);
    wr(17, pb << 12);
    wr(0, 32'h24);
    pulse_irq(8'h04);
    idle(2);
    chk("R8 first offer valid", take_valid, 1);
    chk("R6 first offer line", take_line, 2);
    do_ack();
    chk("R8 bubble after accept", take_valid, 0);
    wr(2, 32'h20);
    idle(2);
    pre = (pb & m) < (pa & m);
    chk("R7 preempt decision", take_valid, pre);
    if (pre) begin
      chk("R7 preempting line", take_line, 5);
      do_ack();
      do_exit(5);
      do_exit(2);
    end else begin
      do_exit(2);
      idle(2);
      chk("R7 released after exit", take_valid, 1);
      chk("R7 released line", take_line, 5);
      do_ack();
      do_exit(5);
    end
    wr(1, 32'hFF);
    idle(1);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R8 watchdog actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int p[N];
    int enm, pm, best, bl;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R9 reset state
    chk("R9 take_valid after reset", take_valid, 0);
    rd(0, d);  chk("R9 enable reset", d, 0);
    rd(2, d);  chk("R9 pending reset", d, 0);
    rd(4, d);  chk("R9 active reset", d, 0);
    rd(5, d);  chk("R9 group code reset", d, 32'h700);
    rd(16, d); chk("R9 urgency reset", d, 0);
    rd(9, d);  chk("R9 unmapped word", d, 0);

    // R1 enable set/clear
    wr(0, 32'h0F); wr(0, 32'h30);
    rd(0, d); chk("R1 set accumulates", d, 32'h3F);
    wr(1, 32'h05);
    rd(1, d); chk("R1 clear ones only", d, 32'h3A);
    wr(1, 32'h0); wr(0, 32'h0);
    rd(0, d); chk("R1 zero writes ignored", d, 32'h3A);
    wr(1, 32'hFF);

    // R2 pending set/clear and request lines
    wr(2, 32'h11);
    rd(3, d); chk("R2 set pending", d, 32'h11);
    wr(3, 32'h01); wr(3, 32'h0);
    rd(2, d); chk("R2 clear ones only", d, 32'h10);
    pulse_irq(8'h80);
    rd(2, d); chk("R2 request line sets pending", d, 32'h90);
    wr(3, 32'hFF);

    // R3 active is read-only
    wr(4, 32'hFF);
    rd(4, d); chk("R3 active ignores writes", d, 0);

    // R4 urgency bytes
    wr(16, 32'hFFFFFFFF);
    rd(16, d); chk("R4 low nibble reads zero", d, 32'hF0F0F0F0);
    wr(17, 32'h12345678);
    rd(17, d); chk("R4 byte per line", d, 32'h10305070);

    // R5 group key
    wr(5, 32'h12340300);
    rd(5, d); chk("R5 write without key ignored", d, 32'h700);
    wr(5, 32'h05FA0400);
    rd(5, d); chk("R5 keyed write", d, 32'h400);

    // R6 waiting order sweep, nothing active
    for (int s = 0; s < 64; s++) begin
      for (int i = 0; i < N; i++) p[i] = ((i * 5 + s * 3) % 16) & ((s & 1) ? 12 : 15);
      enm = 8'hFF ^ (((s & 4) != 0) ? (1 << (s % 8)) : 0);
      pm  = ((s * 37 + 11) & 255) | (1 << ((s + 3) % 8));
      wr(1, 32'hFF);
      wr(0, enm);
      wr(16, (p[0] << 4) | (p[1] << 12) | (p[2] << 20) | (p[3] << 28));
      wr(17, (p[4] << 4) | (p[5] << 12) | (p[6] << 20) | (p[7] << 28));
      wr(2, pm);
      idle(2);
      best = 99; bl = -1;
      for (int i = 0; i < N; i++)
        if (((enm >> i) & 1) && ((pm >> i) & 1) && p[i] < best) begin
          best = p[i]; bl = i;
        end
      chk("R6 offer present", take_valid, (bl >= 0) ? 1 : 0);
      if (bl >= 0) chk("R6 winner line", take_line, bl);
      wr(3, 32'hFF);
      idle(1);
    end
    wr(1, 32'hFF);

    // R7 preemption sweep over every group code and urgency pair
    for (int c = 0; c < 8; c++)
      for (int pa = 0; pa < 16; pa++)
        for (int pb = 0; pb < 16; pb++)
          pair_case(c, pa, pb);

    // R3 accept of line 3 and exit of line 1 in one cycle
    wr(5, 32'h05FA0300);
    wr(16, (8 << 12) | (2 << 28));
    wr(0, 32'h0A);
    pulse_irq(8'h02);
    idle(2);
    do_ack();
    wr(2, 32'h08);
    idle(2);
    chk("R7 nested offer valid", take_valid, 1);
    chk("R7 nested offer line", take_line, 3);
    take_ack = 1'b1; exit_valid = 1'b1; exit_line = IW'(1);
    @(negedge clk);
    take_ack = 1'b0; exit_valid = 1'b0;
    rd(4, d); chk("R3 accept and exit same cycle", d, 32'h08);
    do_exit(3);
    rd(4, d); chk("R3 exit clears", d, 0);
    wr(1, 32'hFF);

    // R2 accept and new request on the same line in one cycle
    wr(0, 32'h40);
    pulse_irq(8'h40);
    idle(2);
    chk("R8 offer line 6", take_line, 6);
    take_ack = 1'b1; irq_req = 8'h40;
    @(negedge clk);
    take_ack = 1'b0; irq_req = '0;
    rd(4, d); chk("R3 line 6 active", d, 32'h40);
    rd(2, d); chk("R2 request beats accept", d, 32'h40);
    wr(3, 32'h40);
    do_exit(6);
    wr(1, 32'hFF);

    // R8 ack after the pending bit was cleared is ignored
    wr(0, 32'h01);
    pulse_irq(8'h01);
    idle(2);
    chk("R8 offer line 0", take_valid, 1);
    wr(3, 32'h01);
    do_ack();
    rd(4, d); chk("R8 stale ack ignored", d, 0);
    rd(2, d); chk("R8 pending stays clear", d, 0);
    idle(2);
    chk("R8 no offer afterwards", take_valid, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule